// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit executes the atomic memory instructions of a 64-bit register-machine virtual instruction set. An issue stage presents one request at a time. Each request carries an access width code, an operation immediate, a computed memory address, the value of the source register and the value of register 0. The unit decodes the immediate and reads the addressed word over a simple synchronous memory port. It combines the old value with the source operand and writes the result back. A lock output stays asserted from the read request until the write is granted, so no other agent can touch the location in between.

The operations are add, or, and, xor, exchange and compare-exchange. A fetch flag in the immediate returns the value memory held before the update. That value goes out on a writeback interface, which targets either the source register or register 0. Only 4-byte and 8-byte accesses are legal. In 4-byte mode the unit works on the low 32 bits only and zero-extends what it returns. A malformed width or immediate produces an illegal-instruction pulse and no memory traffic.

Top module: `atomic_rmw_unit`

## Requirements
- R1: The width code `req_size` is 2'b00 for 4 bytes and 2'b11 for 8 bytes. The codes 2'b01 (2 bytes) and 2'b10 (1 byte) make `illegal` pulse for one cycle, one cycle after acceptance. There is then no memory request and no `done`.
- R2: In the immediate, bits [7:4] select the operation: 0x0 add, 0x4 or, 0x5 and, 0xa xor. Bit 0 is the fetch flag. 0xe1 is exchange and 0xf1 is compare-exchange. Any other value, including any set bit in [31:8] or [3:1], is illegal and handled as in R1.
- R3: Add, or, and and xor store (old memory value OP source register) to the addressed word. An immediate of 0 is add without fetch and raises no writeback.
- R4: With the fetch flag set on a basic operation, the writeback carries the old memory value to the source register (`wb_to_r0` = 0).
- R5: Exchange stores the source register and returns the old memory value to the source register.
- R6: Compare-exchange stores the source register only when the old value equals register 0. In both outcomes it writes the zero-extended old value to register 0 (`wb_to_r0` = 1). On a mismatch no write request is issued.
- R7: In 4-byte mode (`mem_wide` = 0) only the low 32 bits take part. The comparison, the returned old value and the write data all use the low half, and the upper 32 bits of `mem_wdata` and `wb_data` are zero.
- R8: `mem_lock` rises with the read request and stays high until the write is granted, or until read data returns on a compare-exchange mismatch. `req_ready` is low whenever `mem_lock` is high.
- R9: `done` pulses for exactly one cycle: the cycle after the write grant, or the cycle after read data on a compare-exchange mismatch. `wb_valid` is asserted only together with `done`.
- R10: While `mem_req` is high and `mem_gnt` is low, the request, address, direction and write data hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Atomic request present |
| req_ready | output | 1 | Unit idle; request accepted when valid |
| req_size | input | 2 | Access width code |
| req_imm | input | IMM_W | Operation immediate |
| req_addr | input | AW | Target word address |
| req_src | input | XLEN | Source register value |
| req_r0 | input | XLEN | Register 0 value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | 1 = 8-byte access, 0 = low 4 bytes |
| mem_lock | output | 1 | Location locked for the sequence |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | XLEN | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | XLEN | Read data |
| wb_valid | output | 1 | Writeback valid |
| wb_to_r0 | output | 1 | 1 = register 0, 0 = source register |
| wb_data | output | XLEN | Old memory value, zero-extended |
| done | output | 1 | Instruction completed |
| illegal | output | 1 | Illegal-instruction pulse |

## Verification
Two events can coincide: read data returning and the compare-exchange decision. Both are taken in the same cycle from the raw read data, so the compare must use the masked value that has just arrived, never a stale register. The bench provokes this with a memory model that answers a read in the very next cycle and also after several stall cycles. A second coincidence is a grant arriving in the same cycle the request is first raised. Each outcome is judged by the final memory word, the number of write grants and the writeback value, all computed from the requirement arithmetic. Monitors track the lock window and request stability on every cycle.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

   typedef enum logic [2:0] {
      AMO_ADD  = 3'd0,
      AMO_OR   = 3'd1,
      AMO_AND  = 3'd2,
      AMO_XOR  = 3'd3,
      AMO_XCHG = 3'd4,
      AMO_CMPX = 3'd5
   } amo_op_e;

   typedef struct packed {
      amo_op_e op;
      logic    fetch;
      logic    legal;
   } amo_dec_t;

   localparam logic [3:0] SEL_ADD  = 4'h0;
   localparam logic [3:0] SEL_OR   = 4'h4;
   localparam logic [3:0] SEL_AND  = 4'h5;
   localparam logic [3:0] SEL_XOR  = 4'ha;
   localparam logic [3:0] SEL_XCHG = 4'he;
   localparam logic [3:0] SEL_CMPX = 4'hf;

   localparam logic [1:0] SIZE_4B = 2'b00;
   localparam logic [1:0] SIZE_8B = 2'b11;

endpackage

// File: rtl/atomic_rmw_decode.sv
module atomic_rmw_decode
   import atomic_rmw_pkg::*;
#(
   parameter int IMM_W = 32
) (
   input  logic [IMM_W-1:0] imm,
   input  logic [1:0]       size,
   output amo_dec_t         dec,
   output logic             size_ok,
   output logic             wide
);

   logic [3:0] sel;
   logic       fbit;
   logic       pad_zero;

   assign sel      = imm[7:4];
   assign fbit     = imm[0];
   assign pad_zero = (imm[IMM_W-1:8] == '0) && (imm[3:1] == 3'b000);

   always_comb begin
      dec.op    = AMO_ADD;
      dec.fetch = fbit;
      dec.legal = 1'b0;
      unique case (sel)
         SEL_ADD:  begin dec.op = AMO_ADD;  dec.legal = pad_zero; end
         SEL_OR:   begin dec.op = AMO_OR;   dec.legal = pad_zero; end
         SEL_AND:  begin dec.op = AMO_AND;  dec.legal = pad_zero; end
         SEL_XOR:  begin dec.op = AMO_XOR;  dec.legal = pad_zero; end
         SEL_XCHG: begin dec.op = AMO_XCHG; dec.legal = pad_zero && fbit; end
         SEL_CMPX: begin dec.op = AMO_CMPX; dec.legal = pad_zero && fbit; end
         default:  begin dec.op = AMO_ADD;  dec.legal = 1'b0; end
      endcase
   end

   assign size_ok = (size == SIZE_4B) || (size == SIZE_8B);
   assign wide    = (size == SIZE_8B);

   always_comb begin
      if (dec.legal && (dec.op == AMO_XCHG || dec.op == AMO_CMPX))
         assert (dec.fetch) else $error("a_r2_swap_needs_fetch");
   end

endmodule

// File: rtl/atomic_rmw_alu.sv
module atomic_rmw_alu
   import atomic_rmw_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  amo_op_e         op,
   input  logic            wide,
   input  logic [XLEN-1:0] old_val,
   input  logic [XLEN-1:0] src,
   input  logic [XLEN-1:0] r0,
   input  logic [XLEN-1:0] rd_raw,
   output logic [XLEN-1:0] new_val,
   output logic [XLEN-1:0] rd_ext,
   output logic            rd_match
);

   localparam int LANES      = XLEN / 8;
   localparam int HALF_LANES = LANES / 2;

   logic [XLEN-1:0] lane_mask;
   logic [XLEN-1:0] result;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (g < HALF_LANES) begin : g_low
         assign lane_mask[g*8 +: 8] = 8'hFF;
      end else begin : g_high
         assign lane_mask[g*8 +: 8] = {8{wide}};
      end
   end

   assign rd_ext   = rd_raw & lane_mask;
   assign rd_match = (rd_ext == (r0 & lane_mask));

   always_comb begin
      unique case (op)
         AMO_ADD:  result = old_val + src;
         AMO_OR:   result = old_val | src;
         AMO_AND:  result = old_val & src;
         AMO_XOR:  result = old_val ^ src;
         default:  result = src;
      endcase
   end

   assign new_val = result & lane_mask;

endmodule

// File: rtl/atomic_rmw_ctrl.sv
module atomic_rmw_ctrl
   import atomic_rmw_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int AW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  amo_dec_t        dec,
   input  logic            size_ok,
   input  logic            wide_in,
   input  logic [AW-1:0]   req_addr,
   input  logic [XLEN-1:0] req_src,
   input  logic [XLEN-1:0] req_r0,
   input  logic            mem_gnt,
   input  logic            mem_rvalid,
   input  logic [XLEN-1:0] rd_ext,
   input  logic            rd_match,
   input  logic [XLEN-1:0] new_val,
   output amo_op_e         op_q,
   output logic            wide_q,
   output logic [XLEN-1:0] src_q,
   output logic [XLEN-1:0] r0_q,
   output logic [XLEN-1:0] old_q,
   output logic            mem_req,
   output logic            mem_we,
   output logic            mem_wide,
   output logic            mem_lock,
   output logic [AW-1:0]   mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   output logic            wb_valid,
   output logic            wb_to_r0,
   output logic [XLEN-1:0] wb_data,
   output logic            done,
   output logic            illegal
);

   localparam int HALF = XLEN / 2;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RREQ, ST_RWAIT, ST_WREQ, ST_FIN, ST_ILL
   } st_e;

   st_e           state;
   logic          fetch_q;
   logic [AW-1:0] addr_q;
   logic          accept;

   assign accept = req_valid && (state == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         op_q    <= AMO_ADD;
         fetch_q <= 1'b0;
         wide_q  <= 1'b0;
         addr_q  <= '0;
         src_q   <= '0;
         r0_q    <= '0;
         old_q   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (accept) begin
               if (dec.legal && size_ok) begin
                  state   <= ST_RREQ;
                  op_q    <= dec.op;
                  fetch_q <= dec.fetch;
                  wide_q  <= wide_in;
                  addr_q  <= req_addr;
                  src_q   <= req_src;
                  r0_q    <= req_r0;
               end else begin
                  state <= ST_ILL;
               end
            end
            ST_RREQ:  if (mem_gnt) state <= ST_RWAIT;
            ST_RWAIT: if (mem_rvalid) begin
               old_q <= rd_ext;
               state <= (op_q == AMO_CMPX && !rd_match) ? ST_FIN : ST_WREQ;
            end
            ST_WREQ:  if (mem_gnt) state <= ST_FIN;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign mem_req   = (state == ST_RREQ) || (state == ST_WREQ);
   assign mem_we    = (state == ST_WREQ);
   assign mem_lock  = (state == ST_RREQ) || (state == ST_RWAIT) || (state == ST_WREQ);
   assign mem_wide  = wide_q;
   assign mem_addr  = addr_q;
   assign mem_wdata = new_val;
   assign done      = (state == ST_FIN);
   assign illegal   = (state == ST_ILL);
   assign wb_valid  = done && fetch_q;
   assign wb_to_r0  = (op_q == AMO_CMPX);
   assign wb_data   = old_q;

   a_r8_lock_on_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_lock);
   a_r8_no_accept_locked: assert property (@(posedge clk) disable iff (!rst_n)
      mem_lock |-> !req_ready);
   a_r8_lock_starts_read: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_lock) |-> (mem_req && !mem_we));
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> done);
   a_r1_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!mem_req && !mem_lock && !done));
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));
   a_r7_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && !mem_wide) |-> (mem_wdata[XLEN-1:HALF] == '0));
   a_r7_narrow_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !mem_wide) |-> (wb_data[XLEN-1:HALF] == '0));

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
   import atomic_rmw_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int AW    = 8,
   parameter int IMM_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [1:0]       req_size,
   input  logic [IMM_W-1:0] req_imm,
   input  logic [AW-1:0]    req_addr,
   input  logic [XLEN-1:0]  req_src,
   input  logic [XLEN-1:0]  req_r0,
   output logic             mem_req,
   output logic             mem_we,
   output logic             mem_wide,
   output logic             mem_lock,
   output logic [AW-1:0]    mem_addr,
   output logic [XLEN-1:0]  mem_wdata,
   input  logic             mem_gnt,
   input  logic             mem_rvalid,
   input  logic [XLEN-1:0]  mem_rdata,
   output logic             wb_valid,
   output logic             wb_to_r0,
   output logic [XLEN-1:0]  wb_data,
   output logic             done,
   output logic             illegal
);

   initial begin : p_param_check
      assert (XLEN >= 16 && XLEN % 16 == 0) else $error("XLEN must be a multiple of 16");
      assert (IMM_W >= 9) else $error("IMM_W must exceed 8");
      assert (AW >= 1) else $error("AW must be positive");
   end

   amo_dec_t        dec;
   logic            size_ok;
   logic            wide_in;
   amo_op_e         op_q;
   logic            wide_q;
   logic [XLEN-1:0] src_q;
   logic [XLEN-1:0] r0_q;
   logic [XLEN-1:0] old_q;
   logic [XLEN-1:0] new_val;
   logic [XLEN-1:0] rd_ext;
   logic            rd_match;

   atomic_rmw_decode #(.IMM_W(IMM_W)) u_decode (
      .imm     (req_imm),
      .size    (req_size),
      .dec     (dec),
      .size_ok (size_ok),
      .wide    (wide_in)
   );

   atomic_rmw_alu #(.XLEN(XLEN)) u_alu (
      .op       (op_q),
      .wide     (wide_q),
      .old_val  (old_q),
      .src      (src_q),
      .r0       (r0_q),
      .rd_raw   (mem_rdata),
      .new_val  (new_val),
      .rd_ext   (rd_ext),
      .rd_match (rd_match)
   );

   atomic_rmw_ctrl #(.XLEN(XLEN), .AW(AW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .dec        (dec),
      .size_ok    (size_ok),
      .wide_in    (wide_in),
      .req_addr   (req_addr),
      .req_src    (req_src),
      .req_r0     (req_r0),
      .mem_gnt    (mem_gnt),
      .mem_rvalid (mem_rvalid),
      .rd_ext     (rd_ext),
      .rd_match   (rd_match),
      .new_val    (new_val),
      .op_q       (op_q),
      .wide_q     (wide_q),
      .src_q      (src_q),
      .r0_q       (r0_q),
      .old_q      (old_q),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_wide   (mem_wide),
      .mem_lock   (mem_lock),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .wb_valid   (wb_valid),
      .wb_to_r0   (wb_to_r0),
      .wb_data    (wb_data),
      .done       (done),
      .illegal    (illegal)
   );

endmodule

// File: tb/tb_atomic_rmw_unit.sv
module tb_atomic_rmw_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_size = 2'b00;
   logic [31:0] req_imm = '0;
   logic [7:0]  req_addr = '0;
   logic [63:0] req_src = '0;
   logic [63:0] req_r0 = '0;
   logic        mem_req, mem_we, mem_wide, mem_lock;
   logic [7:0]  mem_addr;
   logic [63:0] mem_wdata;
   logic        mem_gnt;
   logic        mem_rvalid;
   logic [63:0] mem_rdata;
   logic        wb_valid, wb_to_r0;
   logic [63:0] wb_data;
   logic        done, illegal;

   always #4 clk = ~clk;

   atomic_rmw_unit #(.XLEN(64), .AW(8), .IMM_W(32)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_size(req_size), .req_imm(req_imm), .req_addr(req_addr),
      .req_src(req_src), .req_r0(req_r0), .mem_req(mem_req), .mem_we(mem_we),
      .mem_wide(mem_wide), .mem_lock(mem_lock), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .wb_valid(wb_valid), .wb_to_r0(wb_to_r0),
      .wb_data(wb_data), .done(done), .illegal(illegal)
   );

   // ---------------- memory model ----------------
   logic [63:0] mem [0:15];
   int          lat_g = 0;
   int          lat_r = 0;
   int          gw;
   int          rcnt;
   logic        pend;
   logic [3:0]  raddr;

   assign mem_gnt    = mem_req && (gw == 0);
   assign mem_rvalid = pend && (rcnt == 0);
   assign mem_rdata  = mem_rvalid ? mem[raddr] : 64'hDEAD_BEEF_DEAD_BEEF;

   always @(posedge clk) begin
      if (!rst_n) begin
         gw   <= 0;
         rcnt <= 0;
         pend <= 1'b0;
      end else begin
         if (mem_gnt || !mem_req) gw <= lat_g;
         else if (gw > 0)         gw <= gw - 1;
         if (mem_rvalid) pend <= 1'b0;
         else if (pend && rcnt > 0) rcnt <= rcnt - 1;
         if (mem_gnt && !mem_we) begin
            pend  <= 1'b1;
            rcnt  <= lat_r;
            raddr <= mem_addr[3:0];
         end
         if (mem_gnt && mem_we) begin
            if (mem_wide) mem[mem_addr[3:0]] <= mem_wdata;
            else          mem[mem_addr[3:0]][31:0] <= mem_wdata[31:0];
         end
      end
   end

   // ---------------- monitors ----------------
   int   reqcyc = 0;
   int   wrcnt = 0;
   int   lock_err = 0;
   int   stab_err = 0;
   logic last_wide = 1'b0;
   logic in_seq = 1'b0;
   logic prev_stall = 1'b0;
   logic [7:0]  prev_addr;
   logic [63:0] prev_wdata;
   logic        prev_we;

   always @(posedge clk) begin
      if (rst_n) begin
         if (mem_req) reqcyc <= reqcyc + 1;
         if (mem_req && !mem_lock) lock_err <= lock_err + 1;
         if (mem_lock && req_ready) lock_err <= lock_err + 1;
         if (in_seq && !mem_lock && !done) lock_err <= lock_err + 1;
         if (mem_gnt && !mem_we) in_seq <= 1'b1;
         if ((mem_gnt && mem_we) || done) in_seq <= 1'b0;
         if (mem_gnt) last_wide <= mem_wide;
         if (mem_gnt && mem_we) wrcnt <= wrcnt + 1;
         if (prev_stall && (!mem_req || mem_addr != prev_addr || mem_we != prev_we
                            || mem_wdata != prev_wdata))
            stab_err <= stab_err + 1;
         prev_stall <= mem_req && !mem_gnt;
         prev_addr  <= mem_addr;
         prev_we    <= mem_we;
         prev_wdata <= mem_wdata;
      end
   end

   // ---------------- checking ----------------
   int n_checks = 0;
   int n_fails = 0;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit imm_ok(input logic [31:0] imm);
      return imm inside {32'h00, 32'h01, 32'h40, 32'h41, 32'h50, 32'h51,
                         32'ha0, 32'ha1, 32'he1, 32'hf1};
   endfunction

   task automatic run_op(input logic [1:0] sz, input logic [31:0] imm,
                         input logic [7:0] adr, input logic [63:0] src,
                         input logic [63:0] r0, input logic [63:0] init);
      logic [63:0] msk, oldv, res, expmem;
      bit    leg, wide, cmpx, wbexp, wr;
      int    rc0, wc0, cyc;
      bit    sd, si;
      logic  wv, wt;
      logic  [63:0] wd;
      string tag;
      wide = (sz == 2'b11);
      msk  = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
      leg  = (sz == 2'b00 || sz == 2'b11) && imm_ok(imm);
      cmpx = (imm == 32'hf1);
      if (!(sz == 2'b00 || sz == 2'b11)) tag = "R1";
      else if (!leg)                     tag = "R2";
      else if (cmpx)                     tag = "R6";
      else if (imm == 32'he1)            tag = "R5";
      else if (imm[0])                   tag = "R4";
      else                               tag = "R3";
      @(negedge clk);
      mem[adr[3:0]] = init;
      oldv = init & msk;
      case (imm[7:4])
         4'h0:    res = oldv + src;
         4'h4:    res = oldv | src;
         4'h5:    res = oldv & src;
         4'ha:    res = oldv ^ src;
         default: res = src;
      endcase
      res    = res & msk;
      wr     = leg && (!cmpx || oldv == (r0 & msk));
      expmem = !wr ? init : (wide ? res : {init[63:32], res[31:0]});
      wbexp  = leg && imm[0];
      req_size = sz; req_imm = imm; req_addr = adr; req_src = src; req_r0 = r0;
      req_valid = 1'b1;
      rc0 = reqcyc; wc0 = wrcnt;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 0;
      while (!(done || illegal) && cyc < 60) begin
         @(negedge clk);
         cyc++;
      end
      sd = done; si = illegal; wv = wb_valid; wt = wb_to_r0; wd = wb_data;
      @(negedge clk);
      check(!done && !illegal, "R9 single-cycle pulse", {62'd0, done, illegal}, 64'd0);
      if (!leg) begin
         check(si && cyc == 0, {tag, " illegal pulse one cycle after accept"},
               64'(cyc), 64'd0);
         check(!sd, {tag, " no done on illegal"}, 64'(sd), 64'd0);
         check(reqcyc == rc0, {tag, " no memory request on illegal"},
               64'(reqcyc - rc0), 64'd0);
         check(mem[adr[3:0]] == init, {tag, " memory untouched"}, mem[adr[3:0]], init);
      end else begin
         check(sd && !si, {tag, " done seen"}, {62'd0, sd, si}, 64'd2);
         check(wv == wbexp, {tag, " R9 writeback valid with done"}, 64'(wv), 64'(wbexp));
         if (wbexp) begin
            check(wt == cmpx, {tag, " writeback target"}, 64'(wt), 64'(cmpx));
            check(wd == oldv, {tag, wide ? " old value" : " R7 old value zero-extended"},
                  wd, oldv);
         end
         check(mem[adr[3:0]] == expmem, {tag, wide ? " memory result" : " R7 low-half result"},
               mem[adr[3:0]], expmem);
         check((wrcnt - wc0) == int'(wr), {tag, " write count"},
               64'(wrcnt - wc0), 64'(wr));
         check(last_wide == wide, "R7 width on memory port", 64'(last_wide), 64'(wide));
      end
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      report();
   end

   initial begin : stim
      logic [31:0] ops [0:8];
      logic [63:0] pat_m [0:1];
      logic [63:0] pat_s [0:1];
      ops[0] = 32'h00; ops[1] = 32'h01; ops[2] = 32'h40; ops[3] = 32'h41;
      ops[4] = 32'h50; ops[5] = 32'h51; ops[6] = 32'ha0; ops[7] = 32'ha1;
      ops[8] = 32'he1;
      pat_m[0] = 64'hFFFF_FFFF_FFFF_FFFF; pat_s[0] = 64'h0000_0000_0000_0001;
      pat_m[1] = 64'h1234_5678_9ABC_DEF0; pat_s[1] = 64'h0F0F_F0F0_5555_AAAA;
      for (int i = 0; i < 16; i++) mem[i] = 64'(i) * 64'h0101_0101_0101_0101;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check(req_ready, "R8 ready after reset", 64'(req_ready), 64'd1);
      check(!mem_req && !mem_lock, "R8 idle memory port after reset",
            {62'd0, mem_req, mem_lock}, 64'd0);
      check(!done && !illegal && !wb_valid, "R9 quiet after reset",
            {61'd0, done, illegal, wb_valid}, 64'd0);

      // basic, fetch and exchange sweep
      for (int l = 0; l < 2; l++) begin
         lat_g = (l == 0) ? 0 : 2;
         lat_r = (l == 0) ? 0 : 3;
         for (int s = 0; s < 2; s++)
            for (int o = 0; o < 9; o++)
               for (int p = 0; p < 2; p++)
                  run_op(s == 0 ? 2'b00 : 2'b11, ops[o], 8'(o + 16 * p),
                         pat_s[p], 64'h0, pat_m[p]);
      end

      // compare-exchange: match, mismatch, narrow match with differing upper half
      for (int l = 0; l < 2; l++) begin
         lat_g = l;
         lat_r = 2 * l;
         run_op(2'b11, 32'hf1, 8'd3, 64'hAAAA_BBBB_CCCC_DDDD,
                64'h1111_2222_3333_4444, 64'h1111_2222_3333_4444);
         run_op(2'b11, 32'hf1, 8'd3, 64'hAAAA_BBBB_CCCC_DDDD,
                64'h1111_2222_3333_4445, 64'h1111_2222_3333_4444);
         run_op(2'b11, 32'hf1, 8'd4, 64'h5, 64'h8000_0000_0000_0000,
                64'h0000_0000_0000_0000);
         run_op(2'b00, 32'hf1, 8'd5, 64'hAAAA_BBBB_CCCC_DDDD,
                64'h9999_0000_3333_4444, 64'h1111_2222_3333_4444);
         run_op(2'b00, 32'hf1, 8'd5, 64'hAAAA_BBBB_CCCC_DDDD,
                64'h1111_2222_3333_4440, 64'h1111_2222_3333_4444);
      end

      // illegal widths
      lat_g = 0; lat_r = 0;
      run_op(2'b01, 32'h00, 8'd6, 64'h1, 64'h0, 64'h77);
      run_op(2'b10, 32'h41, 8'd6, 64'h1, 64'h0, 64'h77);
      run_op(2'b01, 32'hf1, 8'd6, 64'h1, 64'h77, 64'h77);

      // full sweep of the low immediate byte, plus stray upper bits
      for (int v = 0; v < 256; v++)
         run_op(2'b11, 32'(v), 8'd7, 64'h0123_4567_89AB_CDEF, 64'h0,
                64'hFEDC_BA98_7654_3210);
      run_op(2'b11, 32'h0000_0100, 8'd8, 64'h1, 64'h0, 64'h5);
      run_op(2'b00, 32'h8000_0041, 8'd8, 64'h1, 64'h0, 64'h5);

      repeat (4) @(negedge clk);
      check(lock_err == 0, "R8 lock window and ready", 64'(lock_err), 64'd0);
      check(stab_err == 0, "R10 request stable while stalled", 64'(stab_err), 64'd0);
      report();
   end

endmodule